// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers a vector of interrupt request lines and holds, for every line, a pending flag, an enable flag and a 3-bit priority. Each cycle it selects the most urgent request that is pending, enabled and not blocked by the mask threshold. It drives a single interrupt output to the processor when that request may preempt whatever handler is currently running.

Software programs the block through a simple 32-bit register bus. There are write-one-to-set and write-one-to-clear registers for enable and pending, packed priority bytes, a grouping field and a mask threshold. The processor side uses an acknowledge strobe, which takes the presented request and pushes its preemption level, and an end-of-handler strobe, which pops back to the level that was active before. A global enable input gates the output and leaves all stored state untouched.

Register word addresses:

| Address | Write | Read |
|---|---|---|
| 0 | set enable | enable bits |
| 1 | clear enable | enable bits |
| 2 | set pending | pending bits |
| 3 | clear pending | pending bits |
| 4 | grouping, bits [2:0] | grouping |
| 5 | mask threshold, bits [7:0] | mask threshold |
| 8 + k/4 | priority of line k, byte k%4 | priority |

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every enable bit, pending bit, priority, the grouping field and the mask read as zero, and irq_out is low.
- R2: A write to word 0 sets each enable bit whose data bit is 1, and a write to word 1 clears each enable bit whose data bit is 1. Zero data bits leave enables unchanged. Both words read back the enable bits on bits [N-1:0].
- R3: A write to word 2 sets pending bits, and a write to word 3 clears them; both use write-one semantics and both words read back the pending bits. A high irq_in bit sets its pending bit, and a cleared pending request is discarded.
- R4: The priority of line k sits in word 8+k/4, bits [8*(k%4)+7 : 8*(k%4)]. Only the top 3 bits of each byte are kept, and the low 5 bits read as zero.
- R5: Only a line that is both pending and enabled can be presented. irq_id names the line with the numerically smallest priority, and among equal priorities the lowest line number wins.
- R6: A mask of 0 blocks nothing. A nonzero mask M blocks every line whose 8-bit priority byte is M or greater.
- R7: ack while irq_out is high clears the presented line's pending bit and makes its preemption level the active level.
- R8: While a handler is active, a request is presented only if its preemption level is strictly smaller than the active level. The preemption level keeps the top min(G,3) priority bits, where G is the grouping field, and zeroes the rest. G=0 therefore forbids nesting, and G values 3 to 7 behave alike.
- R9: eoi restores the active level that held before the most recent ack. With no handler left active, any pending enabled request is presented.
- R10: With cpu_ie low, irq_out is low, and enable and pending state are unchanged.
- R11: Handlers nest up to 8 deep and unwind in reverse order through eoi.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N | Request lines, each high level sets its pending bit |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cpu_ie | input | 1 | Processor global interrupt enable |
| ack | input | 1 | Processor takes the presented request |
| eoi | input | 1 | Processor finishes the current handler |
| irq_out | output | 1 | Interrupt request to the processor |
| irq_id | output | IDW | Line number of the presented request |

## Verification
All state sits in registers, and irq_out, irq_id and bus_rdata are combinational from that state plus cpu_ie and bus_addr. A write, an irq_in level, an ack or an eoi therefore shows on the outputs one clock edge after it is applied. A change of cpu_ie or bus_addr shows in the same cycle. The driver applies every stimulus just after a rising edge and queues the expected result. The monitor compares that result at the following falling edge, which is after the one edge on which the state updates and before any further stimulus.

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int N = 8,
  parameter int PB = 3,
  parameter int DEPTH = 8,
  parameter int AW = 6,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   irq_in,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic           cpu_ie,
  input  logic           ack,
  input  logic           eoi,
  output logic           irq_out,
  output logic [IDW-1:0] irq_id
);
  localparam int PW  = (N + 3) / 4;
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int SI  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PRI_BASE = 8;

  logic [N-1:0]   en, pend;
  logic [PB-1:0]  prio [N];
  logic [2:0]     grp;
  logic [7:0]     mask;
  logic [PB-1:0]  stk [DEPTH];
  logic [SPW-1:0] sp;

  logic           found;
  logic [IDW-1:0] win;
  logic [PB-1:0]  wprio, pmask, act;
  logic [SI-1:0]  top_i;

  wire wr_sen  = bus_we && bus_addr == AW'(0);
  wire wr_cen  = bus_we && bus_addr == AW'(1);
  wire wr_spd  = bus_we && bus_addr == AW'(2);
  wire wr_cpd  = bus_we && bus_addr == AW'(3);
  wire wr_grp  = bus_we && bus_addr == AW'(4);
  wire wr_mask = bus_we && bus_addr == AW'(5);
  wire [N-1:0] wbits = bus_wdata[N-1:0];

  always_comb begin
    found = 1'b0;
    win   = '0;
    wprio = '1;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && en[i] &&
          (mask == 8'd0 || {prio[i], {(8-PB){1'b0}}} < mask) &&
          (!found || prio[i] < wprio)) begin
        found = 1'b1;
        win   = IDW'(i);
        wprio = prio[i];
      end
    end
  end

  assign pmask = ~({PB{1'b1}} >> ((grp > 3'(PB)) ? PB : int'(grp)));
  assign top_i = SI'(sp - 1'b1);
  assign act   = stk[top_i];

  assign irq_out = cpu_ie && found && sp != SPW'(DEPTH) &&
                   (sp == '0 || (wprio & pmask) < act);
  assign irq_id  = win;

  wire take = ack && irq_out;
  wire [N-1:0] take_bit = take ? (N'(1) << win) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= '0;
      pend <= '0;
      grp  <= '0;
      mask <= '0;
      sp   <= '0;
      for (int i = 0; i < N; i++) prio[i] <= '0;
      for (int d = 0; d < DEPTH; d++) stk[d] <= '0;
    end else begin
      en   <= (en | (wr_sen ? wbits : '0)) & ~(wr_cen ? wbits : '0);
      pend <= ((pend & ~take_bit) | irq_in | (wr_spd ? wbits : '0)) &
              ~(wr_cpd ? wbits : '0);
      if (wr_grp)  grp  <= bus_wdata[2:0];
      if (wr_mask) mask <= bus_wdata[7:0];
      for (int i = 0; i < N; i++)
        if (bus_we && bus_addr == AW'(PRI_BASE + i / 4))
          prio[i] <= bus_wdata[8*(i%4)+7 -: PB];
      if (take) begin
        stk[sp[SI-1:0]] <= wprio & pmask;
        sp <= sp + 1'b1;
      end else if (eoi && sp != '0) begin
        sp <= sp - 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(0), AW'(1): bus_rdata[N-1:0] = en;
      AW'(2), AW'(3): bus_rdata[N-1:0] = pend;
      AW'(4):         bus_rdata[2:0]   = grp;
      AW'(5):         bus_rdata[7:0]   = mask;
      default: begin
        for (int i = 0; i < N; i++)
          if (bus_addr == AW'(PRI_BASE + i / 4))
            bus_rdata[8*(i%4)+7 -: PB] = prio[i];
      end
    endcase
  end
endmodule

module prio_irq_ctrl_chk #(
  parameter int N = 8,
  parameter int PB = 3,
  parameter int DEPTH = 8,
  parameter int IDW = 3,
  parameter int SPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_ie,
  input logic           ack,
  input logic           eoi,
  input logic           irq_out,
  input logic [IDW-1:0] irq_id,
  input logic [N-1:0]   en,
  input logic [N-1:0]   pend,
  input logic [7:0]     mask,
  input logic [PB-1:0]  wprio,
  input logic [SPW-1:0] sp
);
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n) !cpu_ie |-> !irq_out); // R10
  AST_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> (en[irq_id] && pend[irq_id])); // R5
  AST_MASK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) (irq_out && mask != 8'd0) |-> ({wprio, {(8-PB){1'b0}}} < mask)); // R6
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n) (ack && irq_out) |=> sp == $past(sp) + 1'b1); // R7
  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n) (eoi && !(ack && irq_out) && sp != '0) |=> sp == $past(sp) - 1'b1); // R9
  AST_NEST_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sp <= SPW'(DEPTH)); // R11
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N(N), .PB(PB), .DEPTH(DEPTH), .IDW(IDW), .SPW(SPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ie(cpu_ie), .ack(ack), .eoi(eoi),
  .irq_out(irq_out), .irq_id(irq_id), .en(en), .pend(pend),
  .mask(mask), .wprio(wprio), .sp(sp)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/100ps
module prio_irq_ctrl_bench;
  localparam int N = 8;
  localparam int IDW = 3;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_in = '0;
  logic bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic cpu_ie = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic irq_out;
  logic [IDW-1:0] irq_id;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_rd;
    logic        o;
    int          id;
    logic [31:0] rd;
    string       req;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_ie(cpu_ie), .ack(ack), .eoi(eoi), .irq_out(irq_out), .irq_id(irq_id)
  );

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.is_rd) begin
        if (bus_rdata !== e.rd) begin
          failures++;
          $display("FAIL %s read addr %0d: actual %h expected %h", e.req, bus_addr, bus_rdata, e.rd);
        end
      end else if (irq_out !== e.o || (e.o && int'(irq_id) != e.id)) begin
        failures++;
        $display("FAIL %s irq: actual out=%b id=%0d expected out=%b id=%0d", e.req, irq_out, irq_id, e.o, e.id);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    step();
    bus_we = 1'b0;
  endtask

  task automatic chk_rd(input int a, input logic [31:0] d, input string r);
    exp_t e;
    bus_addr = AW'(a);
    e.is_rd = 1'b1; e.o = 1'b0; e.id = 0; e.rd = d; e.req = r;
    q.push_back(e);
    step();
  endtask

  task automatic chk_out(input logic o, input int id, input string r);
    exp_t e;
    e.is_rd = 1'b0; e.o = o; e.id = id; e.rd = '0; e.req = r;
    q.push_back(e);
    step();
  endtask

  task automatic do_ack();
    ack = 1'b1; step(); ack = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; step(); eoi = 1'b0;
  endtask

  initial begin
    step(); step();
    rst_n = 1'b1;
    // R1 reset state
    chk_out(1'b0, 0, "R1");
    chk_rd(0, 32'h0, "R1");
    chk_rd(2, 32'h0, "R1");
    chk_rd(8, 32'h0, "R1");
    chk_rd(4, 32'h0, "R1");
    chk_rd(5, 32'h0, "R1");
    // R2 enable set/clear
    wr(0, 32'h05); chk_rd(0, 32'h05, "R2");
    wr(0, 32'h00); chk_rd(1, 32'h05, "R2");
    wr(1, 32'h04); chk_rd(0, 32'h01, "R2");
    wr(1, 32'h00); chk_rd(0, 32'h01, "R2");
    wr(1, 32'hFF); chk_rd(0, 32'h00, "R2");
    // R4 priority packing and truncation
    wr(8, 32'hFFFFFFFF); chk_rd(8, 32'hE0E0E0E0, "R4");
    wr(8, 32'hFF5F4A7B); chk_rd(8, 32'hE0404060, "R4");
    wr(9, 32'h0); chk_rd(9, 32'h0, "R4");
    // R3 pending set/clear and line input
    wr(2, 32'h0C); chk_rd(3, 32'h0C, "R3");
    wr(3, 32'h04); chk_rd(2, 32'h08, "R3");
    irq_in = 8'h02; step(); irq_in = '0;
    chk_rd(3, 32'h0A, "R3");
    wr(3, 32'hFF); chk_rd(3, 32'h00, "R3");
    // R5 selection
    cpu_ie = 1'b1;
    wr(0, 32'h0F);
    wr(2, 32'h08); chk_out(1'b1, 3, "R5");
    wr(2, 32'h01); chk_out(1'b1, 0, "R5");
    wr(2, 32'h06); chk_out(1'b1, 1, "R5");
    wr(2, 32'h20); chk_out(1'b1, 1, "R5");
    wr(3, 32'hFF); chk_out(1'b0, 0, "R5");
    // R6 mask threshold
    wr(2, 32'h0F);
    wr(5, 32'h40); chk_out(1'b0, 0, "R6");
    wr(5, 32'h41); chk_out(1'b1, 1, "R6");
    chk_rd(5, 32'h41, "R6");
    wr(5, 32'h00); chk_out(1'b1, 1, "R6");
    wr(3, 32'hFF);
    // R10 global gate
    wr(2, 32'h02);
    cpu_ie = 1'b0; chk_out(1'b0, 0, "R10");
    chk_rd(3, 32'h02, "R10");
    chk_rd(1, 32'h0F, "R10");
    cpu_ie = 1'b1; chk_out(1'b1, 1, "R10");
    wr(3, 32'hFF);
    // R7 R8 R9 grouping 3
    wr(4, 3); chk_rd(4, 3, "R8");
    wr(2, 32'h01); chk_out(1'b1, 0, "R7");
    do_ack(); chk_out(1'b0, 0, "R7");
    chk_rd(3, 32'h00, "R7");
    wr(2, 32'h08); chk_out(1'b0, 0, "R8");
    wr(2, 32'h02); chk_out(1'b1, 1, "R8");
    do_ack(); chk_out(1'b0, 0, "R7");
    wr(2, 32'h04); chk_out(1'b0, 0, "R8");
    do_eoi(); chk_out(1'b1, 2, "R9");
    do_eoi(); chk_out(1'b1, 2, "R9");
    do_ack(); chk_out(1'b0, 0, "R8");
    do_eoi(); chk_out(1'b1, 3, "R9");
    do_ack(); do_eoi(); chk_out(1'b0, 0, "R9");
    // R8 grouping 1
    wr(4, 1);
    wr(2, 32'h08); do_ack();
    wr(2, 32'h01); chk_out(1'b1, 0, "R8");
    do_ack();
    wr(2, 32'h02); chk_out(1'b0, 0, "R8");
    do_eoi(); chk_out(1'b1, 1, "R8");
    do_ack(); do_eoi(); do_eoi(); chk_out(1'b0, 0, "R9");
    chk_rd(3, 32'h00, "R7");
    // R8 grouping 0
    wr(4, 0);
    wr(2, 32'h01); do_ack();
    wr(2, 32'h02); chk_out(1'b0, 0, "R8");
    do_eoi(); chk_out(1'b1, 1, "R8");
    do_ack(); do_eoi(); chk_out(1'b0, 0, "R8");
    // R8 grouping 7 acts like 3
    wr(4, 7); chk_rd(4, 7, "R8");
    wr(2, 32'h01); do_ack();
    wr(2, 32'h02); chk_out(1'b1, 1, "R8");
    do_ack(); do_eoi(); do_eoi(); chk_out(1'b0, 0, "R8");
    // R11 eight-deep nesting
    wr(8, 32'h80A0C0E0); wr(9, 32'h00204060); wr(0, 32'hFF);
    for (int i = 0; i < 8; i++) begin
      wr(2, 32'h1 << i); chk_out(1'b1, i, "R11");
      do_ack();
    end
    wr(2, 32'h01); chk_out(1'b0, 0, "R11");
    for (int k = 0; k < 7; k++) do_eoi();
    chk_out(1'b0, 0, "R11");
    do_eoi(); chk_out(1'b1, 0, "R11");
    do_ack(); do_eoi(); chk_out(1'b0, 0, "R11");
    step();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule